// File: doc/BRIEF.md
# Quad Wiper Register Instruction Executor

This block carries out the register commands for four digitally set wipers. Each wiper owns one volatile 8-bit wiper code and a bank of four 8-bit storage slots that stand in for non-volatile memory. The bus slave in front of the block strobes in an instruction byte, any data bytes that follow, and a stop strobe when the bus transaction ends. The executor decodes the instruction, moves bytes between the host, the wiper codes and the slots, and drives the four wiper codes to the resistor arrays. A code of 00h places a wiper nearest its low terminal and FFh nearest its high terminal.

Reads and wiper-code writes act at once. Every command that changes a slot is held until the stop strobe. It is then either committed or dropped, depending on the active-low write-protect pin. A committed store holds a busy flag high for a parameterised number of cycles, which models the non-volatile write time. While busy is high, the block ignores all of its strobes. Reset loads every slot with its factory value and then loads each wiper code from slot 0 of its own bank.

Top module: `wiper_cmd_exec`

## Requirements
- R1: After reset, slot s of wiper w holds FACTORY_BASE + 16*w + s (mod 256). Each wiper code equals its slot 0 value, readByte is 00h and busy is low.
- R2: The instruction byte is split into three fields. Bits [7:4] are the opcode, bits [3:2] select the slot and bits [1:0] select the wiper.
- R3: Opcode 1010 followed by a data byte writes that byte into the selected wiper code. The wiper code output shows it from the cycle after the data strobe. Any further data bytes in the same transaction are ignored. Opcode 1001 loads readByte with the selected wiper code in the cycle after the instruction strobe.
- R4: Opcode 1011 loads readByte with the selected slot in the cycle after the instruction strobe. readByte changes at no other time.
- R5: Opcode 1100 followed by a data byte stores that byte into the selected slot. The slot is written in the cycle after the stop strobe, and only if writeProtectN is high at that stop.
- R6: Opcode 1101 copies the selected slot into the wiper code in the cycle after the instruction strobe. Opcode 1110 copies the wiper code into the selected slot at the stop strobe.
- R7: With bits [1:0] = 00, opcode 0001 loads all four wiper codes from their slot [3:2] at once. Opcode 1000 copies all four wiper codes into their slot [3:2] at the stop strobe.
- R8: A committed store raises busy in the cycle after the stop strobe. Busy stays high for exactly STORE_CYCLES cycles. While busy is high, instruction, data and stop strobes have no effect.
- R9: If writeProtectN is low at the stop strobe, a pending store is dropped. No slot changes and busy stays low.
- R10: The following have no effect: opcodes outside the eight listed, global opcodes with nonzero bits [1:0], and data bytes that do not follow a write instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| instrValid | input | 1 | One-cycle strobe: instrByte is valid |
| instrByte | input | 8 | Instruction byte from the bus slave |
| dataValid | input | 1 | One-cycle strobe: dataByte is valid |
| dataByte | input | 8 | Data byte from the bus slave |
| stopStrobe | input | 1 | One-cycle strobe at the end of a bus transaction |
| writeProtectN | input | 1 | Store enable, active low protect |
| readByte | output | 8 | Byte returned by the last read command |
| busy | output | 1 | High while a modelled store is in progress |
| wiperCodes | output | 32 | Four wiper codes, wiper w in bits [8w+7:8w] |

## Verification
The bench builds the block with STORE_CYCLES = 24 and FACTORY_BASE = 10h. With those values the busy window can be counted to the exact cycle, and several back-to-back stores fit in a short run. Every factory slot also has a distinct value, so a transfer from the wrong slot or the wrong wiper shows up as a wrong code. Stores, recalls and global moves are chained so that each result depends on the one before it. Strobes are also sent during the busy window and under write protect, and the outputs are checked afterwards to show the commands had no effect.

// File: rtl/wcx_pkg.sv
package wcx_pkg;
  localparam int NUM_WIPERS = 4;
  localparam int NUM_SLOTS  = 4;
  localparam int CODE_W     = 8;

  localparam logic [3:0] OP_GRECALL = 4'b0001;
  localparam logic [3:0] OP_GSTORE  = 4'b1000;
  localparam logic [3:0] OP_RDWCR   = 4'b1001;
  localparam logic [3:0] OP_WRWCR   = 4'b1010;
  localparam logic [3:0] OP_RDDR    = 4'b1011;
  localparam logic [3:0] OP_WRDR    = 4'b1100;
  localparam logic [3:0] OP_RECALL  = 4'b1101;
  localparam logic [3:0] OP_STORE   = 4'b1110;

  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_DATA = 2'd1,
    ST_ONE  = 2'd2,
    ST_ALL  = 2'd3
  } storeKind_e;

  typedef struct packed {
    logic              loadRead;
    logic              readFromDr;
    logic              writeWcr;
    logic              recallOne;
    logic              recallAll;
    logic              storeData;
    logic              storeOne;
    logic              storeAll;
    logic [1:0]        wiper;
    logic [1:0]        slot;
    logic [CODE_W-1:0] value;
  } ctrlStrobe_t;
endpackage

// File: rtl/wcx_ctrl.sv
module wcx_ctrl
  import wcx_pkg::*;
#(
  parameter int STORE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [7:0]        instrByte,
  input  logic              dataValid,
  input  logic [CODE_W-1:0] dataByte,
  input  logic              stopStrobe,
  input  logic              writeProtectN,
  output ctrlStrobe_t       strobe,
  output logic              busy
);
  localparam int CNT_W = $clog2(STORE_CYCLES + 1);

  logic [CNT_W-1:0]  busyCnt;
  logic              wantData;
  logic [3:0]        pendOp;
  logic [1:0]        pendWiper;
  logic [1:0]        pendSlot;
  logic [CODE_W-1:0] pendValue;
  storeKind_e        armed;

  logic [3:0] opField;
  logic [1:0] slotField;
  logic [1:0] wiperField;
  logic       acceptStop;
  logic       acceptInstr;
  logic       acceptData;
  logic       commit;

  assign opField     = instrByte[7:4];
  assign slotField   = instrByte[3:2];
  assign wiperField  = instrByte[1:0];
  assign busy        = (busyCnt != '0);
  assign acceptStop  = stopStrobe && !busy;
  assign acceptInstr = instrValid && !busy && !stopStrobe;
  assign acceptData  = dataValid && !busy && !stopStrobe && !instrValid && wantData;
  assign commit      = acceptStop && (armed != ST_NONE) && writeProtectN;

  always_comb begin
    strobe = '0;
    if (acceptInstr) begin
      strobe.wiper = wiperField;
      strobe.slot  = slotField;
      case (opField)
        OP_RDWCR:   strobe.loadRead = 1'b1;
        OP_RDDR: begin
          strobe.loadRead   = 1'b1;
          strobe.readFromDr = 1'b1;
        end
        OP_RECALL:  strobe.recallOne = 1'b1;
        OP_GRECALL: strobe.recallAll = (wiperField == 2'b00);
        default: ;
      endcase
    end else if (acceptData) begin
      strobe.wiper    = pendWiper;
      strobe.slot     = pendSlot;
      strobe.value    = dataByte;
      strobe.writeWcr = (pendOp == OP_WRWCR);
    end else if (commit) begin
      strobe.wiper     = pendWiper;
      strobe.slot      = pendSlot;
      strobe.value     = pendValue;
      strobe.storeData = (armed == ST_DATA);
      strobe.storeOne  = (armed == ST_ONE);
      strobe.storeAll  = (armed == ST_ALL);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt   <= '0;
      wantData  <= 1'b0;
      pendOp    <= '0;
      pendWiper <= '0;
      pendSlot  <= '0;
      pendValue <= '0;
      armed     <= ST_NONE;
    end else begin
      if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end else if (commit) begin
        busyCnt <= CNT_W'(STORE_CYCLES);
      end
      if (acceptStop) begin
        wantData <= 1'b0;
        armed    <= ST_NONE;
      end else if (acceptInstr) begin
        wantData  <= (opField == OP_WRWCR) || (opField == OP_WRDR);
        pendOp    <= opField;
        pendWiper <= wiperField;
        pendSlot  <= slotField;
        if (opField == OP_STORE) begin
          armed <= ST_ONE;
        end else if (opField == OP_GSTORE && wiperField == 2'b00) begin
          armed <= ST_ALL;
        end else begin
          armed <= ST_NONE;
        end
      end else if (acceptData) begin
        wantData <= 1'b0;
        if (pendOp == OP_WRDR) begin
          pendValue <= dataByte;
          armed     <= ST_DATA;
        end
      end
    end
  end

  // R8: busy only ever starts right after a stop strobe
  assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopStrobe));

  // R9: a stop taken with write protect low never starts busy
  assert_wp_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stopStrobe && !busy && !writeProtectN) |=> !busy);
endmodule

// File: rtl/wcx_regs.sv
module wcx_regs
  import wcx_pkg::*;
#(
  parameter logic [CODE_W-1:0] FACTORY_BASE = 8'h80
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  output logic [CODE_W-1:0]            readByte,
  output logic [NUM_WIPERS*CODE_W-1:0] wiperCodes
);
  localparam int FLAT_DR = NUM_WIPERS * NUM_SLOTS * CODE_W;

  logic [NUM_WIPERS*CODE_W-1:0] wcrFlat;
  logic [FLAT_DR-1:0]           drFlat;

  function automatic logic [CODE_W-1:0] factoryCode(input int w, input int s);
    return FACTORY_BASE + CODE_W'(w * 16 + s);
  endfunction

  for (genvar w = 0; w < NUM_WIPERS; w++) begin : gWiper
    logic [CODE_W-1:0] wcrReg;
    logic [CODE_W-1:0] drBank [NUM_SLOTS];
    logic              selMe;

    assign selMe = (strobe.wiper == 2'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wcrReg <= factoryCode(w, 0);
      end else if (strobe.writeWcr && selMe) begin
        wcrReg <= strobe.value;
      end else if ((strobe.recallOne && selMe) || strobe.recallAll) begin
        wcrReg <= drBank[strobe.slot];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < NUM_SLOTS; s++) drBank[s] <= factoryCode(w, s);
      end else if (strobe.storeData && selMe) begin
        drBank[strobe.slot] <= strobe.value;
      end else if ((strobe.storeOne && selMe) || strobe.storeAll) begin
        drBank[strobe.slot] <= wcrReg;
      end
    end

    assign wcrFlat[w*CODE_W +: CODE_W] = wcrReg;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
      assign drFlat[(w*NUM_SLOTS+s)*CODE_W +: CODE_W] = drBank[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readByte <= '0;
    end else if (strobe.loadRead) begin
      if (strobe.readFromDr) begin
        readByte <= drFlat[(int'(strobe.wiper)*NUM_SLOTS + int'(strobe.slot))*CODE_W +: CODE_W];
      end else begin
        readByte <= wcrFlat[int'(strobe.wiper)*CODE_W +: CODE_W];
      end
    end
  end

  assign wiperCodes = wcrFlat;

  // R5: slots only change on a store strobe from the control
  assert_dr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.storeData || strobe.storeOne || strobe.storeAll) |=> $stable(drFlat));

  // R3: wiper codes only change on a write or recall strobe
  assert_wcr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.writeWcr || strobe.recallOne || strobe.recallAll) |=> $stable(wcrFlat));

  // R4: the read byte only changes on a read strobe
  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadRead |=> $stable(readByte));
endmodule

// File: rtl/wiper_cmd_exec.sv
module wiper_cmd_exec
  import wcx_pkg::*;
#(
  parameter int                STORE_CYCLES = 500000,
  parameter logic [CODE_W-1:0] FACTORY_BASE = 8'h80
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         instrValid,
  input  logic [7:0]                   instrByte,
  input  logic                         dataValid,
  input  logic [CODE_W-1:0]            dataByte,
  input  logic                         stopStrobe,
  input  logic                         writeProtectN,
  output logic [CODE_W-1:0]            readByte,
  output logic                         busy,
  output logic [NUM_WIPERS*CODE_W-1:0] wiperCodes
);
  ctrlStrobe_t strobe;

  wcx_ctrl #(.STORE_CYCLES(STORE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .instrValid(instrValid), .instrByte(instrByte),
    .dataValid(dataValid), .dataByte(dataByte),
    .stopStrobe(stopStrobe), .writeProtectN(writeProtectN),
    .strobe(strobe), .busy(busy)
  );

  wcx_regs #(.FACTORY_BASE(FACTORY_BASE)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .readByte(readByte), .wiperCodes(wiperCodes)
  );
endmodule

// File: tb/tb_wiper_cmd_exec.sv
module tb_wiper_cmd_exec;
  localparam int CLK_PERIOD = 10;
  localparam int STORE = 24;
  localparam logic [7:0] BASE = 8'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [7:0] instrByte = '0;
  logic dataValid = 1'b0;
  logic [7:0] dataByte = '0;
  logic stopStrobe = 1'b0;
  logic writeProtectN = 1'b1;
  logic [7:0] readByte;
  logic busy;
  logic [31:0] wiperCodes;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural reference state
  int mWcr [4];
  int mDr [4][4];
  int mRead, mBusy, mArmed, mW, mS, mVal, mOp;
  bit mWant;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_cmd_exec #(.STORE_CYCLES(STORE), .FACTORY_BASE(BASE)) dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrByte(instrByte),
    .dataValid(dataValid), .dataByte(dataByte), .stopStrobe(stopStrobe),
    .writeProtectN(writeProtectN), .readByte(readByte), .busy(busy),
    .wiperCodes(wiperCodes)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < 4; w++) begin
        for (int s = 0; s < 4; s++) mDr[w][s] = (BASE + w*16 + s) % 256;
        mWcr[w] = mDr[w][0];
      end
      mRead = 0; mBusy = 0; mArmed = 0; mWant = 0;
      mW = 0; mS = 0; mVal = 0; mOp = 0;
    end else if (mBusy > 0) begin
      mBusy = mBusy - 1;
    end else if (stopStrobe) begin
      if (mArmed != 0 && writeProtectN) begin
        if (mArmed == 1) mDr[mW][mS] = mVal;
        else if (mArmed == 2) mDr[mW][mS] = mWcr[mW];
        else for (int w = 0; w < 4; w++) mDr[w][mS] = mWcr[w];
        mBusy = STORE;
      end
      mArmed = 0; mWant = 0;
    end else if (instrValid) begin
      mOp = instrByte[7:4]; mS = instrByte[3:2]; mW = instrByte[1:0];
      mWant = (mOp == 10 || mOp == 12);
      mArmed = 0;
      case (mOp)
        9:  mRead = mWcr[mW];
        11: mRead = mDr[mW][mS];
        13: mWcr[mW] = mDr[mW][mS];
        14: mArmed = 2;
        1:  if (mW == 0) for (int w = 0; w < 4; w++) mWcr[w] = mDr[w][mS];
        8:  if (mW == 0) mArmed = 3;
        default: ;
      endcase
    end else if (dataValid && mWant) begin
      mWant = 0;
      if (mOp == 10) mWcr[mW] = dataByte;
      else begin mVal = dataByte; mArmed = 1; end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      for (int w = 0; w < 4; w++) chk({curReq, " model code"}, int'(wiperCodes[w*8 +: 8]), mWcr[w]);
      chk({curReq, " model read"}, int'(readByte), mRead);
      chk({curReq, " model busy"}, int'(busy), int'(mBusy > 0));
    end
  end

  task automatic sendInstr(input logic [7:0] b);
    @(negedge clk); instrValid = 1'b1; instrByte = b;
    @(negedge clk); instrValid = 1'b0;
  endtask
  task automatic sendData(input logic [7:0] b);
    @(negedge clk); dataValid = 1'b1; dataByte = b;
    @(negedge clk); dataValid = 1'b0;
  endtask
  task automatic sendStop();
    @(negedge clk); stopStrobe = 1'b1;
    @(negedge clk); stopStrobe = 1'b0;
  endtask
  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask
  function automatic int code(input int w);
    return int'(wiperCodes[w*8 +: 8]);
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 code0", code(0), 'h10); chk("R1 code1", code(1), 'h20);
    chk("R1 code2", code(2), 'h30); chk("R1 code3", code(3), 'h40);
    chk("R1 read", int'(readByte), 0); chk("R1 busy", int'(busy), 0);

    // R2 R4: read slot 3 of wiper 1
    curReq = "R4";
    sendInstr(8'hBD); chk("R4 R2 read slot", int'(readByte), 'h23); sendStop();

    // R3 write then read wiper code
    curReq = "R3";
    sendInstr(8'hA2); sendData(8'h5A); chk("R3 write code", code(2), 'h5A); sendStop();
    sendInstr(8'h92); chk("R3 read code", int'(readByte), 'h5A); sendStop();

    // R5 store data, R8 busy length
    curReq = "R5";
    sendInstr(8'hCB); sendData(8'hC3); sendStop();
    chk("R8 busy after stop", int'(busy), 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R8 busy cycles", n, STORE);
    sendInstr(8'hBB); chk("R5 stored slot", int'(readByte), 'hC3); sendStop();

    // R6 store wiper code, R8 strobes ignored while busy
    curReq = "R8";
    sendInstr(8'hE4); sendStop();
    sendInstr(8'hA0); sendData(8'h77); sendStop();
    chk("R8 ignored while busy", code(0), 'h10);
    waitIdle();
    chk("R8 after busy", code(0), 'h10);
    curReq = "R6";
    sendInstr(8'hB4); chk("R6 stored code", int'(readByte), 'h10); sendStop();
    sendInstr(8'hDD); chk("R6 recall", code(1), 'h23); sendStop();

    // R9 write protect drops store
    curReq = "R9";
    writeProtectN = 1'b0;
    sendInstr(8'hC0); sendData(8'hEE); sendStop();
    chk("R9 no busy", int'(busy), 0);
    writeProtectN = 1'b1;
    sendInstr(8'hB0); chk("R9 slot kept", int'(readByte), 'h10); sendStop();

    // R7 global recall and global store
    curReq = "R7";
    sendInstr(8'h14);
    chk("R7 grecall0", code(0), 'h10); chk("R7 grecall1", code(1), 'h21);
    chk("R7 grecall2", code(2), 'h31); chk("R7 grecall3", code(3), 'h41);
    sendStop();
    sendInstr(8'hA3); sendData(8'h99); sendStop();
    sendInstr(8'h88); sendStop();
    chk("R7 gstore busy", int'(busy), 1);
    waitIdle();
    sendInstr(8'hBB); chk("R7 gstore w3", int'(readByte), 'h99); sendStop();
    sendInstr(8'hB9); chk("R7 gstore w1", int'(readByte), 'h21); sendStop();

    // R10 no-ops
    curReq = "R10";
    sendInstr(8'h15); sendStop();
    chk("R10 global bad P", code(0), 'h10);
    sendInstr(8'h89); sendStop();
    chk("R10 gstore bad P", int'(busy), 0);
    sendInstr(8'h20); sendStop(); sendInstr(8'h33); sendStop();
    chk("R10 unlisted", code(3), 'h99);
    sendData(8'h01);
    chk("R10 stray data", code(1), 'h21);
    sendInstr(8'hA1); sendData(8'h44); sendData(8'h55); sendStop();
    chk("R10 R3 extra data", code(1), 'h44);
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule